// File: doc/BRIEF.md
# Playback Tone Discriminator and Bit-Clock Regenerator

This block turns a squared two-tone playback signal from a cassette into a serial data stream and a clock that ticks once per bit, ready for a UART receiver. The tone reaches the block as a clean logic-level signal from an external comparator. The block first synchronizes the tone. It then turns every transition, rising or falling, into one event. A short hold-off window suppresses any transition that follows too closely on an accepted one.

Each event arriving while the regenerated clock is low sets that clock high. A counter, stepped by a reference strobe, pulls the clock low again after a fixed number of strobes. With this timeout the clock runs at one period per bit for both tones. On a mark bit, the first event of the bit sets the clock high and a second event arrives while it is still high. On a space bit, the single transition of a half cycle of the low tone brings no second event. Each event records the level the clock had just before that event. That recorded level is the mark/space decision, and it is copied to the serial output when the clock falls. A mode input selects the slow rate: the block then steps its timeout only on every fourth reference strobe, and all tape tones are a quarter as fast.

Top module: `tape_tone_disc`

## Requirements
- R1: Every rising and every falling edge of `tone_in` produces one internal event, unless it comes within `PULSE_CYC` clock cycles after the last accepted event; such an edge is ignored.
- R2: An event arriving while `rclk_x1` is low sets `rclk_x1` high within six clock cycles of the tone edge. Events arriving while it is high neither restart nor extend its timeout.
- R3: `rclk_x1` returns low after exactly `CNT_LIMIT` (default 12) effective reference ticks have been counted since it went high.
- R4: Each event stores the value that `rclk_x1` had just before that event. A stored 1 means the mark tone and a stored 0 means the space tone.
- R5: `ser_data` changes only in the cycle after `rclk_x1` falls, and it then takes the stored decision.
- R6: With `speed_slow` = 0, every `ref_stb` pulse is an effective tick. With `speed_slow` = 1, only every `SLOW_DIV`-th (default 4th) pulse is one.
- R7: After reset `rclk_x1` is 0 and `ser_data` is 1.
- R8: A bit stream is recovered correctly at tape speeds from 95% to 105% of nominal. The encoding is as follows: a 1 bit is two tone transitions spaced half a bit apart, and a 0 bit is one transition. A bit period is 16 effective ticks, and bit k appears on `ser_data` 12 ticks after its first transition.
- R9: With no tone edges, `rclk_x1` settles low and `ser_data` holds its last value.
- R10: A single half cycle of the low tone, that is one transition spanning a whole bit, is decoded as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_in | input | 1 | Squared playback tone, asynchronous |
| ref_stb | input | 1 | One-cycle reference strobe at 16 times the fast bit rate |
| speed_slow | input | 1 | 0 = fast rate, 1 = quarter rate |
| rclk_x1 | output | 1 | Regenerated once-per-bit clock |
| ser_data | output | 1 | Recovered serial data for the UART receiver |

## Verification
A wrong timeout count or a wrong prescaler phase moves the falling edge of `rclk_x1`. Within one bit, this either makes a mark bit's second transition see a low clock or makes a space bit's next transition see a high one, so `ser_data` is wrong at the next fall, about 12 ticks later. A broken hold-off window lets a glitch count as a second transition, and the decision of the current bit flips from space to mark. A decision register that updates after the clock, rather than before, reads every bit as mark. The bench therefore checks the clock level at mid-bit and after the timeout, and the data level shortly after each fall.

// File: rtl/tdisc_pkg.sv
// Shared definitions for the tape tone discriminator.
// Assumes: nothing beyond IEEE 1800-2017.
package tdisc_pkg;

    // Rate selection carried by the speed_slow pin.
    typedef enum logic {
        SPD_FAST = 1'b0,
        SPD_SLOW = 1'b1
    } speed_e;

    // Counter width able to hold the value n.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tdisc_edge.sv
// Synchronizes the tone, detects both edge polarities and emits one-cycle
// events. An edge seen inside the hold-off window after an accepted event is
// dropped.
// Assumes: tone_in is asynchronous; PULSE_CYC >= 1.
module tdisc_edge #(
    parameter int unsigned PULSE_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_in,
    output logic ev_o
);
    import tdisc_pkg::*;

    localparam int unsigned HW = cnt_w(PULSE_CYC);

    logic          s_meta, s_sync, s_del;
    logic          edge_w;
    logic [HW-1:0] hold_q;

    // Two-stage synchronizer plus one delayed copy for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_del  <= 1'b0;
        end else begin
            s_meta <= tone_in;
            s_sync <= s_meta;
            s_del  <= s_sync;
        end
    end

    // Either polarity of change is an edge.
    always_comb edge_w = s_sync ^ s_del;

    // Accept an edge only outside the hold-off window; emit a single strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            ev_o   <= 1'b0;
        end else if (edge_w && hold_q == '0) begin
            hold_q <= HW'(PULSE_CYC);
            ev_o   <= 1'b1;
        end else begin
            ev_o <= 1'b0;
            if (hold_q != '0)
                hold_q <= hold_q - 1'b1;
        end
    end

endmodule

// File: rtl/tdisc_tick.sv
// Derives the effective timeout tick from the reference strobe: every strobe
// in fast mode, every SLOW_DIV-th strobe in slow mode.
// Assumes: ref_stb is a one-cycle pulse; SLOW_DIV >= 1.
module tdisc_tick #(
    parameter int unsigned SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_stb,
    input  logic slow,
    output logic tick_o
);
    import tdisc_pkg::*;

    localparam int unsigned PW = cnt_w(SLOW_DIV);

    generate
        if (SLOW_DIV <= 1) begin : g_nodiv
            // No division requested: the strobe is the tick in both modes.
            always_comb tick_o = ref_stb;
        end else begin : g_div
            logic [PW-1:0] pre_q;
            logic          wrap_w;

            // Last strobe of a prescaler round.
            always_comb wrap_w = (pre_q == PW'(SLOW_DIV - 1));

            // Count strobes modulo SLOW_DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (ref_stb)
                    pre_q <= wrap_w ? '0 : pre_q + 1'b1;
            end

            // Select the tick according to the rate.
            always_comb begin
                if (speed_e'(slow) == SPD_SLOW)
                    tick_o = ref_stb && wrap_w;
                else
                    tick_o = ref_stb;
            end
        end
    endgenerate

endmodule

// File: rtl/tdisc_clkrec.sv
// Regenerated bit clock: set by an event while low, cleared after CNT_LIMIT
// effective ticks. Events while high are ignored. Also emits a strobe in
// the cycle after the clock falls.
// Assumes: ev and tick are one-cycle strobes; CNT_LIMIT >= 2.
module tdisc_clkrec #(
    parameter int unsigned CNT_LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic tick,
    output logic rclk_o,
    output logic fall_o
);
    import tdisc_pkg::*;

    localparam int unsigned CW = cnt_w(CNT_LIMIT);

    logic [CW-1:0] cnt_q;
    logic          last_w;

    // Timeout reached on this tick.
    always_comb last_w = tick && (cnt_q == CW'(CNT_LIMIT - 1));

    // Set on event from low; count ticks while high; clear at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rclk_o <= 1'b0;
            cnt_q  <= '0;
            fall_o <= 1'b0;
        end else if (!rclk_o) begin
            fall_o <= 1'b0;
            cnt_q  <= '0;
            if (ev)
                rclk_o <= 1'b1;
        end else begin
            fall_o <= last_w;
            if (last_w) begin
                rclk_o <= 1'b0;
                cnt_q  <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdisc_decide.sv
// Mark/space decision: stores the clock level seen by each event and moves it
// to the serial output on the fall strobe.
// Assumes: rclk is the registered clock, so its value at an event is the
// value from before that event.
module tdisc_decide (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic rclk,
    input  logic fall,
    output logic ser_o
);
    logic dec_q;

    // Record the clock level at each event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dec_q <= 1'b0;
        else if (ev)
            dec_q <= rclk;
    end

    // Publish the decision on the clock's falling edge; idle level is mark.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_o <= 1'b1;
        else if (fall)
            ser_o <= dec_q;
    end

endmodule

// File: rtl/tape_tone_disc.sv
// Top level: edge events -> regenerated bit clock -> mark/space decision.
// Assumes: ref_stb runs at 16 times the fast bit rate; the tone is already
// squared to logic levels.
module tape_tone_disc #(
    parameter int unsigned PULSE_CYC = 6,
    parameter int unsigned CNT_LIMIT = 12,
    parameter int unsigned SLOW_DIV  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_in,
    input  logic ref_stb,
    input  logic speed_slow,
    output logic rclk_x1,
    output logic ser_data
);
    logic ev_w, tick_w, fall_w;

    tdisc_edge #(.PULSE_CYC(PULSE_CYC)) u_edge (
        .clk(clk), .rst_n(rst_n), .tone_in(tone_in), .ev_o(ev_w)
    );

    tdisc_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .slow(speed_slow),
        .tick_o(tick_w)
    );

    tdisc_clkrec #(.CNT_LIMIT(CNT_LIMIT)) u_clkrec (
        .clk(clk), .rst_n(rst_n), .ev(ev_w), .tick(tick_w),
        .rclk_o(rclk_x1), .fall_o(fall_w)
    );

    tdisc_decide u_decide (
        .clk(clk), .rst_n(rst_n), .ev(ev_w), .rclk(rclk_x1), .fall(fall_w),
        .ser_o(ser_data)
    );

endmodule

// File: rtl/tdisc_chk.sv
// Property checker for tape_tone_disc, attached with bind below.
// Assumes: signals are sampled on the rising clock edge.
module tdisc_chk #(
    parameter int unsigned PULSE_CYC = 6,
    parameter int unsigned CNT_LIMIT = 12
) (
    input logic clk,
    input logic rst_n,
    input logic ev,
    input logic tick,
    input logic ref_stb,
    input logic rclk,
    input logic fall,
    input logic ser
);
    int unsigned gap_q;
    int unsigned hi_q;

    // Cycles since the last event, saturating at the hold-off length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= PULSE_CYC;
        else if (ev)
            gap_q <= 0;
        else if (gap_q < PULSE_CYC)
            gap_q <= gap_q + 1;
    end

    // Ticks counted while the regenerated clock is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !rclk)
            hi_q <= 0;
        else if (tick)
            hi_q <= hi_q + 1;
    end

    p_holdoff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev |-> gap_q >= PULSE_CYC);

    p_rise_on_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rclk) |-> $past(ev));

    p_fall_at_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rclk) |-> hi_q == CNT_LIMIT);

    p_high_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rclk |-> hi_q <= CNT_LIMIT);

    p_ser_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser) |-> $past(fall));

    p_tick_from_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ref_stb);

endmodule

bind tape_tone_disc tdisc_chk #(
    .PULSE_CYC(PULSE_CYC),
    .CNT_LIMIT(CNT_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev(ev_w), .tick(tick_w), .ref_stb(ref_stb),
    .rclk(rclk_x1), .fall(fall_w), .ser(ser_data)
);

// File: tb/sim_tape_tone_disc.sv
// Bench: schedules tone transitions and expected output levels in queues
// and compares them every clock at the falling edge.
module sim_tape_tone_disc;
    localparam int REF_DIV = 16;
    localparam int TK_FAST = REF_DIV;
    localparam int TK_SLOW = REF_DIV * 4;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tone_in = 1'b0;
    logic ref_stb = 1'b0;
    logic speed_slow = 1'b0;
    logic rclk_x1, ser_data;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit timed_out = 1'b0;

    int    tog_q[$];
    int    s_cyc[$];
    int    s_kind[$];
    int    s_exp[$];
    string s_tag[$];

    always #4 clk = ~clk;

    tape_tone_disc u0 (
        .clk(clk), .rst_n(rst_n), .tone_in(tone_in), .ref_stb(ref_stb),
        .speed_slow(speed_slow), .rclk_x1(rclk_x1), .ser_data(ser_data)
    );

    task automatic check(input int kind, input int exp, input string tag);
        logic act;
        act = (kind == 0) ? ser_data : rclk_x1;
        n_chk++;
        if (act !== exp[0]) begin
            n_fail++;
            $display("FAIL %s: %s actual %0b expected %0b at cycle %0d",
                     tag, (kind == 0) ? "ser_data" : "rclk_x1", act, exp[0], cyc);
        end
    endtask

    task automatic add_samp(input int c, input int kind, input int exp, input string tag);
        s_cyc.push_back(c);
        s_kind.push_back(kind);
        s_exp.push_back(exp);
        s_tag.push_back(tag);
    endtask

    // Schedules a bit stream: a 1 bit is two transitions, a 0 bit is one.
    task automatic push_bits(input logic [15:0] pat, input int n, input int pct,
                             input int tk, input string tag);
        int t = cyc + 40;
        int half = (8 * tk * pct) / 100;
        for (int i = 0; i < n; i++) begin
            tog_q.push_back(t);
            if (pat[i])
                tog_q.push_back(t + half);
            add_samp(t + 6 * tk, 1, 1, {tag, " R2 clock high mid-bit"});
            add_samp(t + (27 * tk) / 2, 1, 0, {tag, " R3 clock low after timeout"});
            add_samp(t + (27 * tk) / 2, 0, pat[i],
                     pat[i] ? {tag, " R4 R8 mark bit"} : {tag, " R10 R8 space bit"});
            t = t + 2 * half;
        end
    endtask

    task automatic drain();
        while ((tog_q.size() > 0 || s_cyc.size() > 0) && !timed_out)
            @(negedge clk);
    endtask

    // Per-clock driver and comparator.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        ref_stb <= (cyc % REF_DIV == 0);
        while (tog_q.size() > 0 && tog_q[0] <= cyc) begin
            void'(tog_q.pop_front());
            tone_in <= ~tone_in;
        end
        while (s_cyc.size() > 0 && s_cyc[0] <= cyc) begin
            check(s_kind[0], s_exp[0], s_tag[0]);
            void'(s_cyc.pop_front());
            void'(s_kind.pop_front());
            void'(s_exp.pop_front());
            void'(s_tag.pop_front());
        end
        if (cyc >= WATCHDOG && !timed_out) begin
            timed_out = 1'b1;
            tog_q.delete();
            s_cyc.delete();
            s_kind.delete();
            s_exp.delete();
            s_tag.delete();
        end
    end

    initial begin
        int g;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 0, "R7 reset clock");
        check(0, 1, "R7 reset data");

        // Fast rate at nominal, slow and fast tape speed.
        speed_slow = 1'b0;
        push_bits(16'h0B4D, 12, 100, TK_FAST, "fast 100%");
        drain();
        push_bits(16'h06A3, 12, 95, TK_FAST, "fast 95%");
        drain();
        push_bits(16'h03A5, 12, 105, TK_FAST, "fast 105%");
        drain();

        // Glitch: two edges two cycles apart; only the first may count.
        g = cyc + 40;
        tog_q.push_back(g);
        tog_q.push_back(g + 2);
        add_samp(g + 6 * TK_FAST, 1, 1, "R1 glitch sets clock once");
        add_samp(g + (27 * TK_FAST) / 2, 0, 0, "R1 glitch second edge ignored");
        drain();

        // Slow rate.
        speed_slow = 1'b1;
        push_bits(16'h02D6, 10, 100, TK_SLOW, "R6 slow 100%");
        drain();
        push_bits(16'h004B, 8, 105, TK_SLOW, "R6 slow 105%");
        drain();

        // Idle: clock low and data held at the last bit (0).
        repeat (60 * TK_SLOW) @(negedge clk);
        check(1, 0, "R9 idle clock");
        check(0, 0, "R9 idle data held");

        if (timed_out) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule